// File: doc/BRIEF.md
# Instruction Queue with Static Branch Prediction

This block is the front end of an instruction fetch path. It keeps up to eight 32-bit instructions in a queue and asks for more a whole line at a time. Each line is a 256-bit beat that carries eight aligned instruction words. From the oldest three entries it sends instructions to three execution classes: integer, floating point and branch. Each class accepts at most one instruction per cycle, and only while its ready input is high. Within a class, instructions leave in program order. An instruction may overtake an older one that is still waiting only if it belongs to another class. No instruction ever overtakes a branch that has not yet issued.

Conditional branches use a fixed rule based on direction. If the target lies at a lower address the branch is predicted taken, otherwise it is predicted not taken. Unconditional jumps always redirect. When a branch that redirects issues, every younger entry is dropped, the fetch address moves to the target, and any outstanding line request is abandoned. An abandoned line is recognised by a path tag that changes on every redirect. When the execute side reports a misprediction, the whole queue and any line in flight are discarded. Fetch then restarts at the corrected address. The flush takes priority over a line arriving in the same cycle.

Top module: `iq_static_fetch`

## Requirements
- R1: Instruction format: bits [31:30] give the class (00 integer, 01 floating point, 10 conditional branch, 11 unconditional jump). For the two branch classes, bits [23:0] are a signed word offset, and the target is the branch address plus four times the sign-extended offset.
- R2: While rst is high, no issue output is valid and req_valid is low. In the first cycle after reset, a line request goes out for the aligned line that holds RESET_PC.
- R3: A line request is a single-cycle req_valid with req_addr aligned to 32 bytes. It is made only when at least eight queue slots will be free, and only when no request on the current path is still unanswered. It carries the current path tag on req_tag.
- R4: A returned line fills the queue from the word selected by bits [4:2] of the requested fetch address, up to word 7. Word i belongs to address req_addr + 4*i. A line whose line_tag differs from the current path tag is discarded.
- R5: Each class issues at most one instruction per cycle, and only while its ready input is high. Instructions issue in order within a class, and only from the three oldest entries. Nothing overtakes an unissued branch. An issue decided in one cycle appears on that class's outputs for one cycle, after the next clock edge.
- R6: A conditional branch with a negative offset issues with br_taken high. Fetch continues at its target, and all younger queued or fetched words are dropped.
- R7: A conditional branch with a non-negative offset, zero included, issues with br_taken low. Fetch continues sequentially.
- R8: An unconditional jump always issues with br_taken high and redirects fetch like R6.
- R9: mispredict empties the queue, drops any line in flight or arriving in the same cycle, and suppresses issue in that cycle. A request for the aligned line of mispredict_pc appears after the same edge.
- R10: The queue never holds more than eight instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | output | 1 | Line request pulse |
| req_addr | output | 32 | Line address, 32-byte aligned |
| req_tag | output | 3 | Path tag of the request |
| line_valid | input | 1 | Returned line is present |
| line_data | input | 256 | Eight instruction words, word i in bits [32i+31:32i] |
| line_tag | input | 3 | Tag echoed from the request |
| int_ready | input | 1 | Integer unit can take an instruction |
| fp_ready | input | 1 | Floating-point unit can take an instruction |
| br_ready | input | 1 | Branch unit can take an instruction |
| int_valid | output | 1 | Integer issue valid |
| int_instr | output | 32 | Integer instruction |
| int_pc | output | 32 | Its address |
| fp_valid | output | 1 | Floating-point issue valid |
| fp_instr | output | 32 | Floating-point instruction |
| fp_pc | output | 32 | Its address |
| br_valid | output | 1 | Branch issue valid |
| br_instr | output | 32 | Branch instruction |
| br_pc | output | 32 | Its address |
| br_taken | output | 1 | Static prediction |
| br_target | output | 32 | Computed target |
| mispredict | input | 1 | Execute-side misprediction flush |
| mispredict_pc | input | 32 | Corrected fetch address |

## Verification
An issue decided from the ready inputs driven in one cycle shows up on the class outputs after the next rising edge. The bench therefore samples on the falling edge and compares the outputs against the readies it drove half a cycle earlier. A request triggered by a fill or a flush appears after the same edge that consumed that fill or flush, so the first request after a mispredict is checked at the very next falling edge. The scoreboard walks the predicted path itself and keeps one expected queue per class, so the order checks do not depend on the exact cycle, while the latency-sensitive checks are made at fixed offsets. A line is returned a fixed two cycles after its request. This makes flushes routinely overtake lines in flight, so the discarding of stale lines is exercised.

// File: rtl/iq_pkg.sv
package iq_pkg;
  typedef enum logic [1:0] {
    K_INT   = 2'b00,
    K_FP    = 2'b01,
    K_BCOND = 2'b10,
    K_JUMP  = 2'b11
  } kind_e;

  localparam int UNITS = 3;
  localparam logic [1:0] U_INT = 2'd0;
  localparam logic [1:0] U_FP  = 2'd1;
  localparam logic [1:0] U_BR  = 2'd2;

  function automatic logic [1:0] unit_of(kind_e k);
    case (k)
      K_INT:   return U_INT;
      K_FP:    return U_FP;
      default: return U_BR;
    endcase
  endfunction
endpackage

// File: rtl/iq_decode.sv
module iq_decode
  import iq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IW   = 32,
  parameter int OFFW = 24
) (
  input  logic [IW-1:0] instr,
  input  logic [AW-1:0] pc,
  output logic [1:0]    unit,
  output logic          is_br,
  output logic          taken,
  output logic [AW-1:0] target
);
  localparam int EXT = AW - OFFW - 2;

  kind_e            kind;
  logic [OFFW-1:0]  off;
  logic             unused_mid;

  assign kind       = kind_e'(instr[IW-1 -: 2]);
  assign off        = instr[OFFW-1:0];
  assign unused_mid = ^instr[IW-3:OFFW];

  // R1: word offset scaled by four, sign extended
  assign target = pc + {{EXT{off[OFFW-1]}}, off, 2'b00};
  assign unit   = unit_of(kind);
  assign is_br  = (kind == K_BCOND) || (kind == K_JUMP);
  assign taken  = (kind == K_JUMP) || ((kind == K_BCOND) && off[OFFW-1]);
endmodule

// File: rtl/iq_issue_sel.sv
module iq_issue_sel #(
  parameter int WIN = 3,
  parameter int UW  = 2
) (
  input  logic [WIN-1:0]    vld,
  input  logic [UW-1:0]     unit [WIN],
  input  logic [WIN-1:0]    is_br,
  input  logic [2**UW-1:0]  rdy,
  output logic [WIN-1:0]    go
);
  // R5: an entry waits behind any older window entry of its own class
  // and behind any older branch
  always_comb begin
    for (int k = 0; k < WIN; k++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < k; j++) begin
        if (vld[j] && ((unit[j] == unit[k]) || is_br[j])) blocked = 1'b1;
      end
      go[k] = vld[k] && rdy[unit[k]] && !blocked;
    end
  end
endmodule

// File: rtl/iq_static_fetch.sv
module iq_static_fetch
  import iq_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          IW       = 32,
  parameter int          DEPTH    = 8,
  parameter int          LINE_W   = 8,
  parameter int          OFFW     = 24,
  parameter int          WIN      = 3,
  parameter int          TAGW     = 3,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic                 req_valid,
  output logic [AW-1:0]        req_addr,
  output logic [TAGW-1:0]      req_tag,
  input  logic                 line_valid,
  input  logic [IW*LINE_W-1:0] line_data,
  input  logic [TAGW-1:0]      line_tag,
  input  logic                 int_ready,
  input  logic                 fp_ready,
  input  logic                 br_ready,
  output logic                 int_valid,
  output logic [IW-1:0]        int_instr,
  output logic [AW-1:0]        int_pc,
  output logic                 fp_valid,
  output logic [IW-1:0]        fp_instr,
  output logic [AW-1:0]        fp_pc,
  output logic                 br_valid,
  output logic [IW-1:0]        br_instr,
  output logic [AW-1:0]        br_pc,
  output logic                 br_taken,
  output logic [AW-1:0]        br_target,
  input  logic                 mispredict,
  input  logic [AW-1:0]        mispredict_pc
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int IXW  = $clog2(DEPTH);
  localparam int WB   = $clog2(IW / 8);
  localparam int OW   = $clog2(LINE_W);
  localparam int BOFF = WB + OW;
  localparam int KW   = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [AW-1:0] LINE_BYTES = AW'(LINE_W * (IW / 8));

  logic [IW-1:0]   q_ins [DEPTH];
  logic [AW-1:0]   q_pc  [DEPTH];
  logic [IW-1:0]   nx_ins [DEPTH];
  logic [AW-1:0]   nx_pc  [DEPTH];
  logic [CW-1:0]   cnt_q, cnt_nx;
  logic [AW-1:0]   fetch_pc_q, fetch_pc_nx, line_base_q, aligned_nx;
  logic [OW-1:0]   line_off_q;
  logic            pend_q, pend_nx;
  logic [TAGW-1:0] epoch_q, epoch_nx;

  // issue window
  logic [WIN-1:0]  w_vld, w_br, w_tk, go, go_eff;
  logic [1:0]      w_unit [WIN];
  logic [AW-1:0]   w_tgt  [WIN];

  genvar gk;
  generate
    for (gk = 0; gk < WIN; gk++) begin : g_win
      assign w_vld[gk] = (CW'(gk) < cnt_q);
      iq_decode #(.AW(AW), .IW(IW), .OFFW(OFFW)) u_dec (
        .instr (q_ins[gk]),
        .pc    (q_pc[gk]),
        .unit  (w_unit[gk]),
        .is_br (w_br[gk]),
        .taken (w_tk[gk]),
        .target(w_tgt[gk])
      );
    end
  endgenerate

  iq_issue_sel #(.WIN(WIN), .UW(2)) u_sel (
    .vld  (w_vld),
    .unit (w_unit),
    .is_br(w_br),
    .rdy  ({1'b0, br_ready, fp_ready, int_ready}),
    .go   (go)
  );

  // R9: a flush suppresses issue in its own cycle
  assign go_eff = mispredict ? '0 : go;

  logic            redir;
  logic [KW-1:0]   redir_k;
  logic [AW-1:0]   redir_tgt;
  logic            fill_ok;

  always_comb begin
    redir     = 1'b0;
    redir_k   = '0;
    redir_tgt = '0;
    for (int k = 0; k < WIN; k++) begin
      if (go_eff[k] && w_tk[k]) begin
        redir     = 1'b1;
        redir_k   = KW'(k);
        redir_tgt = w_tgt[k];
      end
    end
  end

  // R4/R9: stale or overridden lines are dropped; flush beats fill
  assign fill_ok = line_valid && pend_q && (line_tag == epoch_q) && !mispredict && !redir;

  // compaction: surviving entries in order, then the new line words
  always_comb begin
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < DEPTH; i++) begin
      nx_ins[i] = '0;
      nx_pc[i]  = '0;
    end
    for (int i = 0; i < DEPTH; i++) begin
      logic keep;
      keep = (CW'(i) < cnt_q) && !mispredict;
      if (i < WIN) begin
        if (go_eff[i]) keep = 1'b0;
      end
      if (redir && (CW'(i) > CW'(redir_k))) keep = 1'b0;
      if (keep && (n < CW'(DEPTH))) begin
        nx_ins[n[IXW-1:0]] = q_ins[i];
        nx_pc[n[IXW-1:0]]  = q_pc[i];
        n = n + 1'b1;
      end
    end
    if (fill_ok) begin
      for (int w = 0; w < LINE_W; w++) begin
        if ((OW'(w) >= line_off_q) && (n < CW'(DEPTH))) begin
          nx_ins[n[IXW-1:0]] = line_data[w*IW +: IW];
          nx_pc[n[IXW-1:0]]  = line_base_q + AW'(w * (IW / 8));
          n = n + 1'b1;
        end
      end
    end
    cnt_nx = n;
  end

  assign fetch_pc_nx = mispredict ? mispredict_pc : (redir ? redir_tgt : fetch_pc_q);
  assign aligned_nx  = {fetch_pc_nx[AW-1:BOFF], BOFF'(0)};
  assign epoch_nx    = epoch_q + TAGW'(mispredict || redir);
  assign pend_nx     = pend_q && !mispredict && !redir && !fill_ok;

  logic req_go;
  assign req_go = !pend_nx && (cnt_nx <= CW'(DEPTH - LINE_W));

  // queue storage, no reset needed
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      q_ins[i] <= nx_ins[i];
      q_pc[i]  <= nx_pc[i];
    end
  end

  // per-class issue selection
  logic [3:0]    u_go;
  logic [IW-1:0] u_ins [4];
  logic [AW-1:0] u_pc  [4];
  logic          sel_tk;
  logic [AW-1:0] sel_tgt;

  always_comb begin
    u_go    = '0;
    sel_tk  = 1'b0;
    sel_tgt = '0;
    for (int u = 0; u < 4; u++) begin
      u_ins[u] = '0;
      u_pc[u]  = '0;
    end
    for (int k = 0; k < WIN; k++) begin
      if (go_eff[k]) begin
        u_go[w_unit[k]]  = 1'b1;
        u_ins[w_unit[k]] = q_ins[k];
        u_pc[w_unit[k]]  = q_pc[k];
        if (w_br[k]) begin
          sel_tk  = w_tk[k];
          sel_tgt = w_tgt[k];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      pend_q     <= 1'b0;
      epoch_q    <= '0;
      fetch_pc_q <= RESET_PC;
      line_base_q <= '0;
      line_off_q <= '0;
      req_valid  <= 1'b0;
      req_addr   <= '0;
      req_tag    <= '0;
      int_valid  <= 1'b0;
      fp_valid   <= 1'b0;
      br_valid   <= 1'b0;
    end else begin
      cnt_q     <= cnt_nx;
      epoch_q   <= epoch_nx;
      req_valid <= req_go;
      if (req_go) begin
        pend_q      <= 1'b1;
        req_addr    <= aligned_nx;
        req_tag     <= epoch_nx;
        line_base_q <= aligned_nx;
        line_off_q  <= fetch_pc_nx[BOFF-1:WB];
        fetch_pc_q  <= aligned_nx + LINE_BYTES;
      end else begin
        pend_q      <= pend_nx;
        fetch_pc_q  <= fetch_pc_nx;
      end
      int_valid <= u_go[U_INT];
      fp_valid  <= u_go[U_FP];
      br_valid  <= u_go[U_BR];
    end
  end

  always_ff @(posedge clk) begin
    int_instr <= u_ins[U_INT];
    int_pc    <= u_pc[U_INT];
    fp_instr  <= u_ins[U_FP];
    fp_pc     <= u_pc[U_FP];
    br_instr  <= u_ins[U_BR];
    br_pc     <= u_pc[U_BR];
    br_taken  <= sel_tk;
    br_target <= sel_tgt;
  end
endmodule

// File: rtl/iq_static_fetch_chk.sv
module iq_static_fetch_chk #(
  parameter int AW     = 32,
  parameter int IW     = 32,
  parameter int DEPTH  = 8,
  parameter int LINE_W = 8,
  parameter int OFFW   = 24,
  parameter int TAGW   = 3
) (
  input logic                      clk,
  input logic                      rst,
  input logic [$clog2(DEPTH+1)-1:0] cnt_q,
  input logic                      req_valid,
  input logic [AW-1:0]             req_addr,
  input logic [TAGW-1:0]           req_tag,
  input logic                      int_valid,
  input logic                      fp_valid,
  input logic                      br_valid,
  input logic [IW-1:0]             br_instr,
  input logic                      br_taken,
  input logic                      mispredict
);
  localparam int BOFF = $clog2(IW / 8) + $clog2(LINE_W);

  logic [1:0] br_kind;
  assign br_kind = br_instr[IW-1 -: 2];

  // R10
  a_r10_capacity: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= ($clog2(DEPTH+1))'(DEPTH));

  // R3
  a_r3_room: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (cnt_q <= ($clog2(DEPTH+1))'(DEPTH - LINE_W)));

  a_r3_aligned: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_addr[BOFF-1:0] == '0));

  a_r3_single: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!req_valid || (req_tag != $past(req_tag))));

  // R6
  a_r6_backward_taken: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_kind == 2'b10 && br_instr[OFFW-1]) |-> br_taken);

  // R7
  a_r7_forward_not_taken: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_kind == 2'b10 && !br_instr[OFFW-1]) |-> !br_taken);

  // R8
  a_r8_jump_taken: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_kind == 2'b11) |-> br_taken);

  // R9
  a_r9_flush_empty: assert property (@(posedge clk) disable iff (rst)
    mispredict |=> (cnt_q == '0));

  a_r9_flush_quiet: assert property (@(posedge clk) disable iff (rst)
    mispredict |=> !(int_valid || fp_valid || br_valid));
endmodule

bind iq_static_fetch iq_static_fetch_chk #(
  .AW(AW), .IW(IW), .DEPTH(DEPTH), .LINE_W(LINE_W), .OFFW(OFFW), .TAGW(TAGW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_q     (cnt_q),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_tag   (req_tag),
  .int_valid (int_valid),
  .fp_valid  (fp_valid),
  .br_valid  (br_valid),
  .br_instr  (br_instr),
  .br_taken  (br_taken),
  .mispredict(mispredict)
);

// File: tb/iq_static_fetch_test.sv
module iq_static_fetch_test;
  localparam int AW = 32, IW = 32, DEPTH = 8, LINE_W = 8, OFFW = 24, TAGW = 3;
  localparam int LAT = 2;
  localparam int GOAL = 400;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid; logic [31:0] req_addr; logic [TAGW-1:0] req_tag;
  logic line_valid = 1'b0; logic [255:0] line_data = '0; logic [TAGW-1:0] line_tag = '0;
  logic int_ready = 1'b1, fp_ready = 1'b1, br_ready = 1'b1;
  logic int_valid, fp_valid, br_valid, br_taken;
  logic [31:0] int_instr, int_pc, fp_instr, fp_pc, br_instr, br_pc, br_target;
  logic mispredict = 1'b0; logic [31:0] mispredict_pc = '0;

  iq_static_fetch #(.AW(AW), .IW(IW), .DEPTH(DEPTH), .LINE_W(LINE_W), .OFFW(OFFW),
                    .TAGW(TAGW), .RESET_PC(32'h0)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_tag(req_tag),
    .line_valid(line_valid), .line_data(line_data), .line_tag(line_tag),
    .int_ready(int_ready), .fp_ready(fp_ready), .br_ready(br_ready),
    .int_valid(int_valid), .int_instr(int_instr), .int_pc(int_pc),
    .fp_valid(fp_valid), .fp_instr(fp_instr), .fp_pc(fp_pc),
    .br_valid(br_valid), .br_instr(br_instr), .br_pc(br_pc),
    .br_taken(br_taken), .br_target(br_target),
    .mispredict(mispredict), .mispredict_pc(mispredict_pc));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  typedef struct { logic [31:0] ins; logic [31:0] pc; logic tk; logic [31:0] tgt; } exp_t;
  exp_t q_int[$], q_fp[$], q_br[$];
  logic [31:0] wpc = 32'h0;

  typedef struct { logic [31:0] addr; logic [TAGW-1:0] tag; int due; int seq; } resp_t;
  resp_t mem_q[$];

  // program image (R1 encoding)
  function automatic logic [31:0] prog(input logic [31:0] a);
    int w; logic [1:0] k; logic [23:0] f;
    w = int'(a[31:2]);
    f = a[25:2];
    k = ((w % 4) == 1 || (w % 4) == 2) ? 2'b01 : 2'b00;
    case (w)
      4:   begin k = 2'b10; f = 24'd3; end
      7:   begin k = 2'b11; f = 24'd9; end
      18:  begin k = 2'b10; f = -24'sd2; end
      80:  begin k = 2'b10; f = 24'd5; end
      90:  begin k = 2'b10; f = -24'sd3; end
      200: begin k = 2'b11; f = -24'sd200; end
      default: ;
    endcase
    return {k, a[7:2], f};
  endfunction

  // walk one instruction of the predicted path
  task automatic step();
    exp_t e; logic [1:0] k; logic [23:0] off;
    e.ins = prog(wpc); e.pc = wpc;
    k = e.ins[31:30]; off = e.ins[23:0];
    e.tgt = wpc + {{6{off[23]}}, off, 2'b00};
    e.tk  = (k == 2'b11) || (k == 2'b10 && off[23]);
    if (k == 2'b00) q_int.push_back(e);
    else if (k == 2'b01) q_fp.push_back(e);
    else q_br.push_back(e);
    wpc = e.tk ? e.tgt : wpc + 32'd4;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic fill_to(input int u);
    for (int g = 0; g < 64; g++) begin
      if ((u == 0 && q_int.size() != 0) || (u == 1 && q_fp.size() != 0) ||
          (u == 2 && q_br.size() != 0)) break;
      step();
    end
  endtask

  initial begin
    int cyc = 0, issued = 0, br_cnt = 0, seq = 0, last_seq = -1, mark = 0, stale = 0;
    int mis_idx = 0;
    bit open = 0, mis_pend = 0, first = 1;
    logic [31:0] mis_list [4] = '{32'h104, 32'h30C, 32'h168, 32'h2F0};
    logic [15:0] lfsr = 16'hACE1;
    exp_t e;

    repeat (4) begin
      @(negedge clk);
      // R2: reset state
      chk(!int_valid && !fp_valid && !br_valid && !req_valid, "R2 reset outputs",
          {28'd0, int_valid, fp_valid, br_valid, req_valid}, 32'd0);
    end
    rst = 1'b0;

    forever begin
      @(negedge clk);
      cyc++;
      if (first) begin
        // R2: first request for the reset line
        chk(req_valid && req_addr == 32'h0, "R2 first request", req_addr, 32'h0);
        first = 0;
      end
      if (mis_pend) begin
        // R9: flush refetches from corrected line, no issue
        chk(req_valid && req_addr == {mispredict_pc[31:5], 5'd0}, "R9 refetch address",
            req_addr, {mispredict_pc[31:5], 5'd0});
        chk(!int_valid && !fp_valid && !br_valid, "R9 no issue in flush cycle",
            {29'd0, int_valid, fp_valid, br_valid}, 32'd0);
        mispredict = 1'b0;
        mis_pend = 0;
      end

      // R5: issue only while ready (ready driven at previous negedge)
      if (int_valid) chk(int_ready, "R5 int ready", 32'(int_ready), 32'd1);
      if (fp_valid)  chk(fp_ready,  "R5 fp ready",  32'(fp_ready),  32'd1);
      if (br_valid)  chk(br_ready,  "R5 br ready",  32'(br_ready),  32'd1);

      // scoreboard monitor
      if (int_valid) begin
        fill_to(0); e = q_int.pop_front();
        chk(int_instr == e.ins && int_pc == e.pc, "R5 int order/R4 fill", int_pc, e.pc);
        issued++;
      end
      if (fp_valid) begin
        fill_to(1); e = q_fp.pop_front();
        chk(fp_instr == e.ins && fp_pc == e.pc, "R5 fp order/R4 fill", fp_pc, e.pc);
        issued++;
      end
      if (br_valid) begin
        fill_to(2); e = q_br.pop_front();
        chk(br_instr == e.ins && br_pc == e.pc, "R5 br order", br_pc, e.pc);
        if (e.ins[31:30] == 2'b11)
          chk(br_taken == e.tk, "R8 jump taken", 32'(br_taken), 32'(e.tk));
        else if (e.ins[23])
          chk(br_taken == e.tk, "R6 backward taken", 32'(br_taken), 32'(e.tk));
        else
          chk(br_taken == e.tk, "R7 forward not taken", 32'(br_taken), 32'(e.tk));
        chk(br_target == e.tgt, "R1 target", br_target, e.tgt);
        if (br_taken) begin
          open = 0;
          mark = seq;
        end
        issued++;
        br_cnt++;
      end

      // requests
      if (req_valid) begin
        chk(req_addr[4:0] == 5'd0, "R3 aligned", req_addr, {req_addr[31:5], 5'd0});
        chk(!open, "R3 one live request", 32'(open), 32'd0);
        mem_q.push_back('{addr: req_addr, tag: req_tag, due: cyc + LAT, seq: seq});
        last_seq = seq;
        seq++;
        open = 1;
      end

      // memory responses
      line_valid = 1'b0;
      if (mem_q.size() != 0 && mem_q[0].due <= cyc) begin
        resp_t r;
        r = mem_q.pop_front();
        for (int i = 0; i < LINE_W; i++) line_data[i*32 +: 32] = prog(r.addr + 32'(4*i));
        line_tag = r.tag;
        line_valid = 1'b1;
        if (r.seq < mark) stale++;
        if (r.seq == last_seq) open = 0;
      end

      // execute-side misprediction every sixth branch
      if (br_valid && (br_cnt % 6) == 0) begin
        mispredict = 1'b1;
        mispredict_pc = mis_list[mis_idx % 4];
        mis_idx++;
        q_int.delete(); q_fp.delete(); q_br.delete();
        wpc = mispredict_pc;
        open = 0;
        mark = seq;
        mis_pend = 1;
      end

      // ready pattern
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (cyc > 150) begin
        int_ready = lfsr[0] | lfsr[1];
        fp_ready  = lfsr[2] | lfsr[3];
        br_ready  = lfsr[4] | lfsr[5];
      end

      if (issued >= GOAL && !mis_pend) begin
        // R4: stale lines were delivered and none disturbed the streams
        chk(stale > 0, "R4 stale lines exercised", 32'(stale), 32'd1);
        chk(mis_idx >= 4, "R9 flushes exercised", 32'(mis_idx), 32'd4);
        finished = 1'b1;
        summary();
        $finish;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule